// File: doc/BRIEF.md
# Transmit Descriptor Sequencer

This block drives the transmit side of an Ethernet MAC from a small descriptor memory. While transmit is enabled it polls the descriptor at a configured index. A descriptor is two consecutive words: a status/length word at the index and a buffer pointer at index+1. When the ready flag is set, the block takes the descriptor and clears its error bookkeeping in the status copy it carries. It then settles the per-frame length limits and whether a CRC will be appended. After that it pulls the payload from system memory one 32-bit word per cycle into a local word buffer. Finally it offers the frame on a valid/ready output, where the buffer can be read by word index.

The controller has four named states. IDLE moves to WAIT_DESC when transmit is enabled. WAIT_DESC reads the status word; when ready is set it reads the pointer word on the next cycle and moves to READ_FIFO. When ready is clear it stays while transmit is enabled and returns to IDLE when it is not. READ_FIFO fetches words until the byte count reaches the descriptor length, then moves to TRANSMIT. TRANSMIT holds the frame until the consumer accepts it and then returns to IDLE.

Per-frame decisions combine descriptor flags with global mode flags. The pad flags choose the minimum length, the huge-frame flag chooses the maximum length, and the CRC flags decide whether four bytes are added to the reported length.

Top module: `tx_bd_ctrl`

## Requirements
- R1: After reset the block is in IDLE: frame_valid, bd_rd_en and mem_rd are all 0.
- R2: While cfg_tx_en is 0 in IDLE, no descriptor read is made (bd_rd_en stays 0) and no frame is produced.
- R3: The status word is read at cfg_desc_idx and the pointer word at cfg_desc_idx+1. The status word holds the length in bits 31:16, ready in bit 15, last in bit 13, pad in bit 12 and CRC request in bit 11. With ready clear the block keeps polling the same index while cfg_tx_en is 1, and returns to IDLE without reading memory once cfg_tx_en is 0. The descriptor port and the memory port are never active in the same cycle.
- R4: frame_status equals the accepted status word with bits 8:0 cleared. These bits are no-carrier, defer, collision, retransmit, the four retry-count bits 7:4 and underrun in bit 8. All other bits are unchanged.
- R5: frame_min_len is cfg_min_len when the descriptor pad bit or cfg_pad_en is 1; otherwise it is the descriptor length.
- R6: frame_max_len is the descriptor length when cfg_huge_en is 1; otherwise it is cfg_max_len.
- R7: frame_crc is 1 when cfg_crc_en is 1, or when the descriptor has both its CRC bit and its last bit set. frame_len is the descriptor length plus 4 when frame_crc is 1, and the descriptor length otherwise.
- R8: For length L, exactly ceil(L/4) memory reads are made, the k-th at pointer+4k. Buffer word k then holds the data returned for that read.
- R9: frame_valid stays 1, with frame_len, frame_status and the other frame outputs stable, until frame_ready is seen. In the cycle after acceptance frame_valid is 0 and the block is back in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_en | input | 1 | Global transmit enable |
| cfg_pad_en | input | 1 | Global pad enable |
| cfg_huge_en | input | 1 | Global huge-frame enable |
| cfg_crc_en | input | 1 | Global CRC enable |
| cfg_min_len | input | 16 | Configured minimum frame length |
| cfg_max_len | input | 16 | Configured maximum frame length |
| cfg_desc_idx | input | DESC_AW | Index of the descriptor status word |
| bd_rd_en | output | 1 | Descriptor memory read strobe |
| bd_rd_addr | output | DESC_AW | Descriptor memory word address |
| bd_rd_data | input | 32 | Descriptor memory data, same cycle |
| mem_rd | output | 1 | Payload memory read strobe |
| mem_addr | output | ADDR_W | Payload byte address |
| mem_data | input | 32 | Payload memory data, same cycle |
| frame_valid | output | 1 | Frame ready for the consumer |
| frame_ready | input | 1 | Consumer accepts the frame |
| frame_len | output | 17 | Frame length including CRC bytes |
| frame_min_len | output | 16 | Minimum length chosen for this frame |
| frame_max_len | output | 16 | Maximum length chosen for this frame |
| frame_crc | output | 1 | CRC is to be appended |
| frame_status | output | 32 | Status word with error bits cleared |
| frame_rd_idx | input | BUF_IW | Buffer word index to read |
| frame_rd_data | output | 32 | Buffer word at frame_rd_idx |

## Verification
The bench builds the block with DESC_AW=4, BUF_WORDS=16 and ADDR_W=32. A 16-word buffer lets lengths from 0 to 64 bytes fill it completely, and a 16-entry descriptor memory lets every even index be used. It sweeps all 64 combinations of the three descriptor flags and three mode flags across lengths around every word boundary, from zero up to a full buffer. For each frame it computes the limits, CRC choice, status, read count and word contents arithmetically. Separate runs cover polling a descriptor that is not ready and withdrawing transmit enable while waiting.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_DESC,
        ST_READ_FIFO,
        ST_TRANSMIT
    } tbd_state_e;

    localparam int LEN_W     = 16;
    localparam int LEN_LSB   = 16;
    localparam int READY_BIT = 15;
    localparam int LAST_BIT  = 13;
    localparam int PAD_BIT   = 12;
    localparam int CRC_BIT   = 11;
    localparam int CRC_BYTES = 4;

    // underrun, retry[3:0], retransmit, collision, defer, no-carrier
    localparam logic [31:0] ERR_CLEAR_MASK = 32'h0000_01FF;

endpackage

// File: rtl/tbd_policy.sv
module tbd_policy
    import tbd_pkg::*;
(
    input  logic [31:0]      desc_word,
    input  logic             mode_pad,
    input  logic             mode_huge,
    input  logic             mode_crc,
    input  logic [LEN_W-1:0] cfg_min_len,
    input  logic [LEN_W-1:0] cfg_max_len,
    output logic [LEN_W-1:0] min_len,
    output logic [LEN_W-1:0] max_len,
    output logic             add_crc,
    output logic [LEN_W:0]   wire_len,
    output logic [31:0]      clean_status
);
    logic [LEN_W-1:0] desc_len;

    always_comb begin
        desc_len     = desc_word[LEN_LSB +: LEN_W];
        min_len      = (desc_word[PAD_BIT] || mode_pad) ? cfg_min_len : desc_len;
        max_len      = mode_huge ? desc_len : cfg_max_len;
        add_crc      = mode_crc || (desc_word[CRC_BIT] && desc_word[LAST_BIT]);
        wire_len     = {1'b0, desc_len} + (add_crc ? (LEN_W+1)'(CRC_BYTES) : '0);
        clean_status = desc_word & ~ERR_CLEAR_MASK;
    end
endmodule

// File: rtl/tbd_wordbuf.sv
module tbd_wordbuf #(
    parameter  int DEPTH = 16,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;
endmodule

// File: rtl/tx_bd_ctrl.sv
module tx_bd_ctrl
    import tbd_pkg::*;
#(
    parameter  int DESC_AW   = 4,
    parameter  int ADDR_W    = 32,
    parameter  int BUF_WORDS = 16,
    localparam int BUF_IW    = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1,
    localparam int CNT_W     = LEN_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_tx_en,
    input  logic               cfg_pad_en,
    input  logic               cfg_huge_en,
    input  logic               cfg_crc_en,
    input  logic [LEN_W-1:0]   cfg_min_len,
    input  logic [LEN_W-1:0]   cfg_max_len,
    input  logic [DESC_AW-1:0] cfg_desc_idx,
    output logic               bd_rd_en,
    output logic [DESC_AW-1:0] bd_rd_addr,
    input  logic [31:0]        bd_rd_data,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [31:0]        mem_data,
    output logic               frame_valid,
    input  logic               frame_ready,
    output logic [LEN_W:0]     frame_len,
    output logic [LEN_W-1:0]   frame_min_len,
    output logic [LEN_W-1:0]   frame_max_len,
    output logic               frame_crc,
    output logic [31:0]        frame_status,
    input  logic [BUF_IW-1:0]  frame_rd_idx,
    output logic [31:0]        frame_rd_data
);
    tbd_state_e       state_q, state_d;
    logic             ptr_phase_q;
    logic [31:0]      status_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0] bytes_q;
    logic [LEN_W-1:0] min_q, max_q;
    logic             crc_q;
    logic [LEN_W:0]   len_q;

    logic [LEN_W-1:0] pol_min, pol_max;
    logic             pol_crc;
    logic [LEN_W:0]   pol_len;
    logic [31:0]      pol_status;

    logic             accept_desc;
    logic             fetch_more;
    logic [CNT_W-1:0] body_len;
    logic             buf_wr;

    tbd_policy u_policy (
        .desc_word    (bd_rd_data),
        .mode_pad     (cfg_pad_en),
        .mode_huge    (cfg_huge_en),
        .mode_crc     (cfg_crc_en),
        .cfg_min_len  (cfg_min_len),
        .cfg_max_len  (cfg_max_len),
        .min_len      (pol_min),
        .max_len      (pol_max),
        .add_crc      (pol_crc),
        .wire_len     (pol_len),
        .clean_status (pol_status)
    );

    assign body_len    = CNT_W'(status_q[LEN_LSB +: LEN_W]);
    assign fetch_more  = (state_q == ST_READ_FIFO) && (bytes_q < body_len);
    assign accept_desc = (state_q == ST_WAIT_DESC) && !ptr_phase_q && bd_rd_data[READY_BIT];
    assign buf_wr      = fetch_more && (int'(bytes_q[CNT_W-1:2]) < BUF_WORDS);

    tbd_wordbuf #(.DEPTH(BUF_WORDS)) u_buf (
        .clk     (clk),
        .wr_en   (buf_wr),
        .wr_idx  (bytes_q[2 +: BUF_IW]),
        .wr_data (mem_data),
        .rd_idx  (frame_rd_idx),
        .rd_data (frame_rd_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cfg_tx_en) state_d = ST_WAIT_DESC;
            ST_WAIT_DESC: begin
                if (ptr_phase_q)                  state_d = ST_READ_FIFO;
                else if (!bd_rd_data[READY_BIT] && !cfg_tx_en) state_d = ST_IDLE;
            end
            ST_READ_FIFO: if (!fetch_more) state_d = ST_TRANSMIT;
            ST_TRANSMIT:  if (frame_ready) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            ptr_phase_q <= 1'b0;
            status_q    <= '0;
            ptr_q       <= '0;
            bytes_q     <= '0;
            min_q       <= '0;
            max_q       <= '0;
            crc_q       <= 1'b0;
            len_q       <= '0;
        end else begin
            state_q <= state_d;
            if (accept_desc) begin
                ptr_phase_q <= 1'b1;
                status_q    <= pol_status;
                min_q       <= pol_min;
                max_q       <= pol_max;
                crc_q       <= pol_crc;
                len_q       <= pol_len;
            end else if (state_q == ST_WAIT_DESC && ptr_phase_q) begin
                ptr_phase_q <= 1'b0;
                ptr_q       <= ADDR_W'(bd_rd_data);
                bytes_q     <= '0;
            end
            if (fetch_more) bytes_q <= bytes_q + CNT_W'(4);
        end
    end

    // outputs
    always_comb begin
        bd_rd_en      = (state_q == ST_WAIT_DESC);
        bd_rd_addr    = cfg_desc_idx + DESC_AW'(ptr_phase_q);
        mem_rd        = fetch_more;
        mem_addr      = ptr_q + ADDR_W'(bytes_q);
        frame_valid   = (state_q == ST_TRANSMIT);
        frame_len     = len_q;
        frame_min_len = min_q;
        frame_max_len = max_q;
        frame_crc     = crc_q;
        frame_status  = status_q;
    end

    // R1: nothing active right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !frame_valid && !mem_rd && !bd_rd_en);

    // R2: disabled and idle means no descriptor read next cycle
    p_idle_no_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cfg_tx_en) |=> !bd_rd_en);

    // R3: the two read ports never overlap
    p_ports_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bd_rd_en && mem_rd));

    // R4: error bits are clear whenever a frame is offered
    p_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_status & ERR_CLEAR_MASK) == '0);

    // R7: reported length relates to carried length and CRC choice
    p_crc_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> frame_len ==
            ({1'b0, frame_status[LEN_LSB +: LEN_W]} + (frame_crc ? (LEN_W+1)'(CRC_BYTES) : '0)));

    // R8: consecutive fetches step by one word
    p_fetch_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> mem_addr == $past(mem_addr) + ADDR_W'(4));

    // R9: offer held stable until taken
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_ready) |=> frame_valid && $stable(frame_len) && $stable(frame_status));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_ready) |=> !frame_valid);
endmodule

// File: tb/tx_bd_ctrl_tb.sv
module tx_bd_ctrl_tb;
    localparam int DESC_AW = 4;
    localparam int BUF_W   = 16;
    localparam int BUF_IW  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, pad_en = 1'b0, huge_en = 1'b0, crc_en = 1'b0;
    logic [15:0] min_len = 16'd46, max_len = 16'd1518;
    logic [DESC_AW-1:0] idx = '0;
    logic        bd_rd_en;
    logic [DESC_AW-1:0] bd_rd_addr;
    logic [31:0] bd_rd_data;
    logic        mem_rd;
    logic [31:0] mem_addr, mem_data;
    logic        frame_valid;
    logic        frame_ready = 1'b0;
    logic [16:0] frame_len;
    logic [15:0] frame_min_len, frame_max_len;
    logic        frame_crc;
    logic [31:0] frame_status;
    logic [BUF_IW-1:0] rd_idx = '0;
    logic [31:0] rd_data;

    logic [31:0] desc [16];
    int checks = 0, fails = 0;
    int rd_cnt = 0;
    logic rd_clr = 1'b0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    assign bd_rd_data = desc[bd_rd_addr];
    assign mem_data   = {~mem_addr[15:0], mem_addr[15:0]};

    always @(posedge clk) begin
        if (rd_clr) rd_cnt <= 0;
        else if (mem_rd) rd_cnt <= rd_cnt + 1;
    end

    tx_bd_ctrl #(.DESC_AW(DESC_AW), .ADDR_W(32), .BUF_WORDS(BUF_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_tx_en(tx_en), .cfg_pad_en(pad_en), .cfg_huge_en(huge_en), .cfg_crc_en(crc_en),
        .cfg_min_len(min_len), .cfg_max_len(max_len), .cfg_desc_idx(idx),
        .bd_rd_en(bd_rd_en), .bd_rd_addr(bd_rd_addr), .bd_rd_data(bd_rd_data),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .frame_valid(frame_valid), .frame_ready(frame_ready), .frame_len(frame_len),
        .frame_min_len(frame_min_len), .frame_max_len(frame_max_len), .frame_crc(frame_crc),
        .frame_status(frame_status), .frame_rd_idx(rd_idx), .frame_rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (frame_valid) begin ok = 1'b1; break; end
        end
    endtask

    task automatic run_frame(input int len, input logic [5:0] fl, input int di);
        logic [31:0] st, ptr, exp_st;
        int nwords, exp_min, exp_max, exp_len;
        bit ecrc, ok;
        ptr = 32'h0001_0000 + 32'(di) * 32'h100;
        st  = {16'(len), 1'b1, 1'b0, fl[0], fl[1], fl[2], 2'b00, 9'h1FF};
        desc[di] = st;
        desc[di+1] = ptr;
        @(negedge clk);
        idx = DESC_AW'(di);
        pad_en = fl[3]; huge_en = fl[4]; crc_en = fl[5];
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        tx_en = 1'b1;
        wait_valid(ok);
        chk("R9 frame offered", 32'(ok), 32'd1);
        tx_en = 1'b0;
        exp_min = (fl[1] || fl[3]) ? int'(min_len) : len;
        exp_max = fl[4] ? len : int'(max_len);
        ecrc    = fl[5] || (fl[2] && fl[0]);
        exp_len = len + (ecrc ? 4 : 0);
        exp_st  = st & ~32'h1FF;
        nwords  = (len + 3) / 4;
        chk("R5 min len", 32'(frame_min_len), 32'(exp_min));
        chk("R6 max len", 32'(frame_max_len), 32'(exp_max));
        chk("R7 crc flag", 32'(frame_crc), 32'(ecrc));
        chk("R7 frame len", 32'(frame_len), 32'(exp_len));
        chk("R4 status", frame_status, exp_st);
        chk("R8 read count", 32'(rd_cnt), 32'(nwords));
        for (int k = 0; k < nwords; k++) begin
            rd_idx = BUF_IW'(k);
            #1;
            chk("R8 buffer word", rd_data, word_at(ptr + 32'(4 * k)));
        end
        @(negedge clk);
        chk("R9 held", {15'd0, frame_valid, frame_len[15:0]}, {15'd0, 1'b1, 16'(exp_len)});
        frame_ready = 1'b1;
        @(negedge clk);
        frame_ready = 1'b0;
        chk("R9 released", 32'(frame_valid), 32'd0);
        @(negedge clk);
        chk("R2 idle after drop", 32'(bd_rd_en), 32'd0);
    endtask

    initial begin
        int lens[10] = '{0, 1, 3, 4, 5, 8, 17, 33, 63, 64};
        bit ok;
        for (int i = 0; i < 16; i++) desc[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid", 32'(frame_valid), 32'd0);
        chk("R1 bd read", 32'(bd_rd_en), 32'd0);
        chk("R1 mem read", 32'(mem_rd), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: disabled, nothing moves
        desc[0] = {16'd8, 1'b1, 15'd0};
        desc[1] = 32'h2000;
        repeat (6) @(negedge clk);
        chk("R2 no poll", 32'(bd_rd_en), 32'd0);
        chk("R2 no frame", 32'(frame_valid), 32'd0);
        // R3: polling a not-ready descriptor
        desc[6] = {16'd8, 1'b0, 15'd0};
        desc[7] = 32'h3000;
        idx = 4'd6;
        tx_en = 1'b1;
        repeat (8) @(negedge clk);
        chk("R3 polling", 32'(bd_rd_en), 32'd1);
        chk("R3 poll addr", 32'(bd_rd_addr), 32'd6);
        chk("R3 no mem", 32'(rd_cnt), 32'd0);
        chk("R3 no frame", 32'(frame_valid), 32'd0);
        tx_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R3 back idle", 32'(bd_rd_en), 32'd0);
        chk("R3 no mem after drop", 32'(rd_cnt), 32'd0);
        // R3: readiness appears while polling
        tx_en = 1'b1;
        repeat (3) @(negedge clk);
        desc[6] = {16'd8, 1'b1, 15'd0};
        wait_valid(ok);
        tx_en = 1'b0;
        chk("R3 late ready frame", 32'(ok), 32'd1);
        chk("R3 pointer word used", 32'(rd_cnt), 32'd2);
        rd_idx = '0;
        #1;
        chk("R3 pointer word used", rd_data, word_at(32'h3000));
        frame_ready = 1'b1;
        @(negedge clk);
        frame_ready = 1'b0;
        @(negedge clk);
        // sweep
        for (int l = 0; l < 10; l++)
            for (int f = 0; f < 64; f++)
                run_frame(lens[l], 6'(f), 2 * ((l + f) % 8));
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule